// File: doc/BRIEF.md
# Widening Absolute-Difference Accumulate Unit

This block is a packed-SIMD datapath stage. It takes two 128-bit source vectors and a 128-bit accumulator vector. From each source it selects either the low or the high 64-bit half. It cuts that half into lanes of 8, 16 or 32 bits. For each lane pair it forms the difference between the first and second operand and takes its magnitude without loss. It then adds that magnitude into the matching accumulator lane, which is twice as wide as the source lane.

A decode stage drives the block with a lane-size code, a half selector, a signedness mode and the three operand vectors, qualified by `in_valid`. The updated 128-bit accumulator value appears one clock later with `out_valid`. The reserved size code is reported on `out_illegal`, and in that case the accumulator passes through unchanged.

Top module: `wabd_unit`

## Requirements
- R1: `in_size` selects the source lane width as 8 << `in_size`: code 0 gives 8-bit lanes (8 of them), code 1 gives 16-bit lanes (4), and code 2 gives 32-bit lanes (2). For these codes `out_illegal` is 0.
- R2: Code 3 on `in_size` is reserved. It produces `out_illegal` = 1 and `out_result` equal to the `acc_in` presented with it.
- R3: With `in_upper` = 0 the lanes come from bits 63:0 of both sources. With `in_upper` = 1 they come from bits 127:64 of both sources.
- R4: With `in_unsigned` = 0, lanes are two's-complement values and each lane computes `src_a` lane minus `src_b` lane. The magnitude is kept at full precision, so 8-bit -128 against 127 yields 255.
- R5: With `in_unsigned` = 1, lanes are read as unsigned values. All other behaviour is the same as in R4.
- R6: Each accumulator lane is twice the source lane width. The sum of the accumulator lane and the magnitude wraps modulo 2^(2·width).
- R7: Source lane e of the selected half (starting at bit e·width) updates accumulator lane e, which starts at bit e·2·width.
- R8: `out_valid` equals `in_valid` of the previous cycle. `out_result` and `out_illegal` update only on a valid input and otherwise hold their values.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_illegal` and `out_result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| in_size | input | 2 | Lane size code (0: 8, 1: 16, 2: 32, 3: reserved) |
| in_upper | input | 1 | 0 selects bits 63:0, 1 selects bits 127:64 |
| in_unsigned | input | 1 | 1 reads lanes as unsigned, 0 as signed |
| src_a | input | 128 | First source vector (minuend) |
| src_b | input | 128 | Second source vector (subtrahend) |
| acc_in | input | 128 | Accumulator vector |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | 128 | Updated accumulator vector |
| out_illegal | output | 1 | Reserved size code was used |

## Verification
The assertions assume that every control input is a known 0 or 1 whenever `in_valid` is high. They also assume that `acc_in` stays meaningful for the cycle that the reserved-code check compares against. The stimulus meets both conditions: it drives every input from the negative clock edge and drops `in_valid` between transactions. It never leaves a control undriven. The sweep covers every 8-bit operand pair in both signedness modes, with lanes taken from the upper half. It also covers pseudo-random vectors for all four size codes and both halves, plus fixed vectors for the largest signed difference, equal operands and all-ones accumulator lanes.

// File: rtl/wabd_pkg.sv
package wabd_pkg;

    localparam int VEC_W  = 128;
    localparam int HALF_W = VEC_W / 2;
    localparam int NUM_SIZES = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } lane_size_e;

    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic [VEC_W-1:0] result;
    } wabd_out_t;

    function automatic int src_lane_bits(input int code);
        return 8 << code;
    endfunction

    function automatic logic size_is_legal(input lane_size_e sz);
        return sz != SZ_RSVD;
    endfunction

endpackage

// File: rtl/wabd_half_sel.sv
module wabd_half_sel #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]   vec,
    input  logic               upper,
    output logic [VEC_W/2-1:0] half
);
    localparam int HW = VEC_W / 2;

    always_comb begin
        half = upper ? vec[VEC_W-1:HW] : vec[HW-1:0];
    end

endmodule

// File: rtl/wabd_lane.sv
module wabd_lane #(
    parameter int SRC_W = 8
) (
    input  logic [SRC_W-1:0]   a,
    input  logic [SRC_W-1:0]   b,
    input  logic [2*SRC_W-1:0] acc,
    input  logic               unsigned_mode,
    output logic [2*SRC_W-1:0] sum
);
    localparam int EXT_W = SRC_W + 1;
    localparam int ACC_W = 2 * SRC_W;

    logic [EXT_W-1:0] ext_a;
    logic [EXT_W-1:0] ext_b;
    logic [EXT_W-1:0] diff;
    logic [EXT_W-1:0] neg_diff;
    logic [SRC_W-1:0] mag;

    always_comb begin
        ext_a    = {(~unsigned_mode) & a[SRC_W-1], a};
        ext_b    = {(~unsigned_mode) & b[SRC_W-1], b};
        diff     = ext_a - ext_b;
        neg_diff = ~diff + {{(EXT_W-1){1'b0}}, 1'b1};
        mag      = diff[EXT_W-1] ? neg_diff[SRC_W-1:0] : diff[SRC_W-1:0];
        sum      = acc + {{(ACC_W-SRC_W){1'b0}}, mag};
    end

    always_comb begin
        if (a == b) begin
            AST_EQUAL_NO_CHANGE: assert (sum == acc); // R4
        end
    end

endmodule

// File: rtl/wabd_bank.sv
module wabd_bank #(
    parameter int HALF_W = 64,
    parameter int SRC_W  = 8
) (
    input  logic [HALF_W-1:0]   a_half,
    input  logic [HALF_W-1:0]   b_half,
    input  logic [2*HALF_W-1:0] acc,
    input  logic                unsigned_mode,
    output logic [2*HALF_W-1:0] res
);
    localparam int LANES = HALF_W / SRC_W;
    localparam int ACC_W = 2 * SRC_W;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        wabd_lane #(.SRC_W(SRC_W)) lane_i (
            .a             (a_half[e*SRC_W +: SRC_W]),
            .b             (b_half[e*SRC_W +: SRC_W]),
            .acc           (acc[e*ACC_W +: ACC_W]),
            .unsigned_mode (unsigned_mode),
            .sum           (res[e*ACC_W +: ACC_W])
        );
    end

endmodule

// File: rtl/wabd_unit.sv
module wabd_unit
    import wabd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_size,
    input  logic             in_upper,
    input  logic             in_unsigned,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] acc_in,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_result,
    output logic             out_illegal
);
    lane_size_e        size_code;
    logic [HALF_W-1:0] a_half;
    logic [HALF_W-1:0] b_half;
    logic [VEC_W-1:0]  bank_res [NUM_SIZES];
    logic [VEC_W-1:0]  next_res;
    logic              legal;
    wabd_out_t         out_q;

    assign size_code = lane_size_e'(in_size);
    assign legal     = size_is_legal(size_code);

    wabd_half_sel #(.VEC_W(VEC_W)) sel_a_i (
        .vec   (src_a),
        .upper (in_upper),
        .half  (a_half)
    );

    wabd_half_sel #(.VEC_W(VEC_W)) sel_b_i (
        .vec   (src_b),
        .upper (in_upper),
        .half  (b_half)
    );

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_bank
        wabd_bank #(
            .HALF_W (HALF_W),
            .SRC_W  (src_lane_bits(s))
        ) bank_i (
            .a_half        (a_half),
            .b_half        (b_half),
            .acc           (acc_in),
            .unsigned_mode (in_unsigned),
            .res           (bank_res[s])
        );
    end

    always_comb begin
        unique case (size_code)
            SZ_BYTE: next_res = bank_res[0];
            SZ_HALF: next_res = bank_res[1];
            SZ_WORD: next_res = bank_res[2];
            default: next_res = acc_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= in_valid;
            if (in_valid) begin
                out_q.illegal <= ~legal;
                out_q.result  <= next_res;
            end
        end
    end

    assign out_valid   = out_q.valid;
    assign out_illegal = out_q.illegal;
    assign out_result  = out_q.result;

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && !out_illegal && out_result == '0)); // R9
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R8
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(out_result) && $stable(out_illegal))); // R8
    AST_RSVD_PASSTHRU: assert property (@(posedge clk) disable iff (rst) (in_valid && in_size == 2'd3) |=> (out_illegal && out_result == $past(acc_in))); // R2
    AST_LEGAL_NOFLAG: assert property (@(posedge clk) disable iff (rst) (in_valid && in_size != 2'd3) |=> !out_illegal); // R1

endmodule

// File: tb/wabd_unit_tb_top.sv
module wabd_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   in_size;
    logic         in_upper;
    logic         in_unsigned;
    logic [127:0] src_a;
    logic [127:0] src_b;
    logic [127:0] acc_in;
    logic         out_valid;
    logic [127:0] out_result;
    logic         out_illegal;

    int checks = 0;
    int bad    = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    wabd_unit dut_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_size     (in_size),
        .in_upper    (in_upper),
        .in_unsigned (in_unsigned),
        .src_a       (src_a),
        .src_b       (src_b),
        .acc_in      (acc_in),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_illegal (out_illegal)
    );

    function automatic logic [63:0] rnd64();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    function automatic logic [127:0] model(input logic [1:0] sz, input logic up,
                                           input logic un, input logic [127:0] a,
                                           input logic [127:0] b, input logic [127:0] acc);
        logic [127:0] res;
        logic [63:0]  ha, hb, m1, m2, lane;
        longint       va, vb, d;
        int           w;
        if (sz == 2'd3) return acc;
        w   = 8 << sz;
        ha  = up ? a[127:64] : a[63:0];
        hb  = up ? b[127:64] : b[63:0];
        m1  = (64'd1 << w) - 64'd1;
        m2  = (w == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2 * w)) - 64'd1);
        res = '0;
        for (int e = 0; e < 64 / w; e++) begin
            va = longint'((ha >> (e * w)) & m1);
            vb = longint'((hb >> (e * w)) & m1);
            if (!un && va[w-1]) va = va - (longint'(1) << w);
            if (!un && vb[w-1]) vb = vb - (longint'(1) << w);
            d = va - vb;
            if (d < 0) d = -d;
            lane = 64'((acc >> (e * 2 * w))) & m2;
            lane = (lane + 64'(d)) & m2;
            res  = res | (128'(lane) << (e * 2 * w));
        end
        return res;
    endfunction

    task automatic check_txn(input logic [1:0] sz, input logic up, input logic un,
                             input logic [127:0] a, input logic [127:0] b,
                             input logic [127:0] acc, input string req);
        logic [127:0] exp_r;
        exp_r = model(sz, up, un, a, b, acc);
        @(negedge clk);
        in_valid = 1'b1; in_size = sz; in_upper = up; in_unsigned = un;
        src_a = a; src_b = b; acc_in = acc;
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b1 || out_result !== exp_r || out_illegal !== (sz == 2'd3)) begin
            bad++;
            $display("FAIL %s: valid=%b illegal=%b result=%h expected valid=1 illegal=%b result=%h",
                     req, out_valid, out_illegal, out_result, (sz == 2'd3), exp_r);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [127:0] a, b, acc, held;
        rst = 1'b1; in_valid = 1'b0; in_size = '0; in_upper = 1'b0; in_unsigned = 1'b0;
        src_a = '0; src_b = '0; acc_in = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_result !== '0) begin
            bad++;
            $display("FAIL R9: valid=%b illegal=%b result=%h expected 0/0/0", out_valid, out_illegal, out_result);
        end
        rst = 1'b0;

        // R4 R1: largest signed difference -128 minus 127 = 255 in every byte lane
        check_txn(2'd0, 1'b0, 1'b0, {64'h0, {8{8'h80}}}, {64'h0, {8{8'h7F}}}, '0, "R4");
        // R4: equal operands leave accumulator unchanged
        check_txn(2'd1, 1'b1, 1'b0, {64'h8001_7FFF_1234_0000, 64'h0}, {64'h8001_7FFF_1234_0000, 64'h0},
                  {2{64'hDEAD_BEEF_0BAD_F00D}}, "R4");
        // R6: all-ones accumulator lanes wrap
        check_txn(2'd0, 1'b0, 1'b0, {64'h0, {8{8'h05}}}, {64'h0, {8{8'h02}}}, {128{1'b1}}, "R6");
        check_txn(2'd2, 1'b1, 1'b1, {64'hFFFF_FFFF_0000_0000, 64'h0}, {64'h0000_0000_FFFF_FFFF, 64'h0},
                  {128{1'b1}}, "R6");
        check_txn(2'd2, 1'b0, 1'b0, {64'h0, 64'h8000_0000_7FFF_FFFF}, {64'h0, 64'h7FFF_FFFF_8000_0000},
                  {128{1'b1}}, "R6");
        // R2: reserved size code
        check_txn(2'd3, 1'b0, 1'b0, {128{1'b1}}, '0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R2");

        // R8: idle cycle holds outputs and drops valid
        held = out_result;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_result !== held || out_illegal !== 1'b1) begin
            bad++;
            $display("FAIL R8: valid=%b result=%h illegal=%b expected valid=0 result=%h illegal=1",
                     out_valid, out_result, out_illegal, held);
        end

        // R4 R5 R3 R7: exhaustive byte pairs, upper half, distinct subtrahend per lane
        for (int un = 0; un < 2; un++) begin
            for (int av = 0; av < 256; av++) begin
                for (int g = 0; g < 32; g++) begin
                    a = {{8{8'(av)}}, 64'h0};
                    b = '0;
                    for (int e = 0; e < 8; e++) b[64 + e*8 +: 8] = 8'(g * 8 + e);
                    acc = {rnd64(), rnd64()};
                    check_txn(2'd0, 1'b1, 1'(un), a, b, acc, un ? "R5" : "R4");
                end
            end
        end

        // R1 R3 R7: pseudo-random vectors across sizes, halves and modes
        for (int i = 0; i < 800; i++) begin
            a   = {rnd64(), rnd64()};
            b   = {rnd64(), rnd64()};
            acc = {rnd64(), rnd64()};
            check_txn(2'(i % 4), 1'((i / 4) % 2), 1'((i / 8) % 2), a, b, acc, "R7");
        end

        // R3: upper half used, lower half ignored
        check_txn(2'd1, 1'b1, 1'b0, {64'h0003_0003_0003_0003, 64'h7FFF_7FFF_7FFF_7FFF},
                  {64'h0001_0001_0001_0001, 64'h8000_8000_8000_8000}, '0, "R3");

        // R9: reset mid-stream
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        checks++;
        if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_result !== '0) begin
            bad++;
            $display("FAIL R9: valid=%b illegal=%b result=%h expected 0/0/0", out_valid, out_illegal, out_result);
        end

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule